// File: doc/BRIEF.md
# Flow-Control Pause Frame Generator

This block produces an IEEE 802.3x flow-control pause frame as a byte stream for the MAC transmit path. Software raises a pause request. The request waits until any frame already on the transmit path has finished. The block then sends a 60-byte frame with no FCS. A CRC inserter downstream appends the FCS, and later stages add the preamble and drive the PHY.

The frame fields come from three packed configuration words:

- **Station address, lower word:** MAC bytes 0 to 3.
- **Station address, upper word:** MAC bytes 4 and 5, plus the EtherType.
- **Control word:** the MAC-control opcode in its upper half and the pause quanta in its lower half.

All fields are captured when the frame starts, so the frame on the wire is always self-consistent. The pending-request flag clears itself when the final byte is accepted downstream.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset, `tx_valid_o`, `tx_last_o` and `pause_pending_o` are all low.
- R2: A one-cycle pulse on `pause_req_i` sets `pause_pending_o` at the next clock edge. With the path free and full duplex selected, `tx_valid_o` rises at the edge after that.
- R3: While `tx_busy_i` is high, no pause frame starts. The frame starts at the first clock edge on which `tx_busy_i` is sampled low.
- R4: While `full_duplex_i` is low, no pause frame starts and the request stays pending.
- R5: Bytes 0 to 5 carry the destination address 01-80-C2-00-00-01, in that order.
- R6: Bytes 6 to 11 carry the source address, MAC byte 0 first:
  - bytes 6 to 9 come from `stn_addr_lo_i` bits 31:24, 23:16, 15:8 and 7:0;
  - bytes 10 and 11 come from `stn_addr_hi_i` bits 31:24 and 23:16.
- R7: Bytes 12 and 13 carry the EtherType from `stn_addr_hi_i` bits 15:8 then 7:0. The value normally programmed there is 0x8808.
- R8: Bytes 14 and 15 carry the opcode from `op_quanta_i` bits 31:24 then 23:16. The value normally programmed there is 0x0001. Bytes 16 and 17 carry the pause quanta from `op_quanta_i` bits 15:8 then 7:0.
- R9: Bytes 18 to 59 are zero. `tx_last_o` is high on byte 59 only, and `tx_valid_o` drops after that byte is accepted.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold their values.
- R11: The address and control words are sampled when the frame starts. Changing them while the frame is being sent has no effect on that frame.
- R12: `pause_pending_o` clears when byte 59 is accepted. A new `pause_req_i` pulse in that same cycle keeps it set, and a second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stn_addr_lo_i | input | 32 | Station MAC bytes 0..3, byte 0 in bits 31:24 |
| stn_addr_hi_i | input | 32 | MAC bytes 4,5 in bits 31:16; EtherType in bits 15:0 |
| op_quanta_i | input | 32 | Opcode in bits 31:16; pause quanta in bits 15:0 |
| full_duplex_i | input | 1 | High when the link runs full duplex |
| pause_req_i | input | 1 | Pulse that requests one pause frame |
| tx_busy_i | input | 1 | High while another frame occupies the transmit path |
| tx_ready_i | input | 1 | Downstream accepts the current byte |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | `tx_data_o` holds a frame byte |
| tx_last_o | output | 1 | Current byte is the final byte before FCS |
| pause_pending_o | output | 1 | A pause frame is requested and not yet completed |

## Verification
The hardest case to reach from the ports is a new request that lands in exactly the cycle the last byte is accepted. Here the set must win over the self-clear, and a second frame must follow after a one-cycle gap. The bench drives the request pulse from the same negative-edge step that raises ready on byte 59. This places both events on one clock edge. The bench also covers three other situations:

- Mid-frame changes: the bench scrambles every configuration word after the first byte is accepted, to show the fields were captured at start.
- Backpressure: random ready patterns test that data holds under stall.
- Start gating: random busy intervals test the deferred start.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

   typedef logic [7:0] byte_t;

   typedef struct packed {
      logic [47:0] src;
      logic [15:0] ethtype;
      logic [15:0] opcode;
      logic [15:0] quanta;
   } pause_fields_t;

   // Byte k of a 48-bit address, counting from the most significant byte.
   function automatic byte_t addr_byte(input logic [47:0] v, input int unsigned k);
      logic [47:0] sh;
      sh = v << (8 * k);
      return sh[47:40];
   endfunction

endpackage

// File: rtl/pfg_req_ctrl.sv
module pfg_req_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic done_i,
   input  logic idle_i,
   input  logic busy_i,
   input  logic fd_i,
   output logic pending_o,
   output logic start_o
);

   logic pending_q;

   // A new request wins over the self-clear of a finishing frame.
   always_ff @(posedge clk) begin
      if (!rst_n)      pending_q <= 1'b0;
      else if (set_i)  pending_q <= 1'b1;
      else if (done_i) pending_q <= 1'b0;
   end

   assign pending_o = pending_q;
   assign start_o   = pending_q & idle_i & ~busy_i & fd_i;

   p_set_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> pending_o);

   p_clear_on_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !set_i) |=> !pending_o);

endmodule

// File: rtl/pfg_field_latch.sv
module pfg_field_latch
   import pfg_pkg::*;
#(
   parameter bit          TYPE_FROM_REG   = 1'b1,
   parameter bit          OPCODE_FROM_REG = 1'b1,
   parameter logic [15:0] FIXED_TYPE      = 16'h8808,
   parameter logic [15:0] FIXED_OPCODE    = 16'h0001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture_i,
   input  logic [31:0]   lo_i,
   input  logic [31:0]   hi_i,
   input  logic [31:0]   opq_i,
   output pause_fields_t fields_o
);

   logic [15:0]   type_sel;
   logic [15:0]   opc_sel;
   pause_fields_t nxt;
   pause_fields_t q;

   generate
      if (TYPE_FROM_REG) begin : g_type_reg
         assign type_sel = hi_i[15:0];
      end else begin : g_type_fixed
         assign type_sel = FIXED_TYPE;
      end
      if (OPCODE_FROM_REG) begin : g_opc_reg
         assign opc_sel = opq_i[31:16];
      end else begin : g_opc_fixed
         assign opc_sel = FIXED_OPCODE;
      end
   endgenerate

   always_comb begin
      nxt.src     = {lo_i, hi_i[31:16]};
      nxt.ethtype = type_sel;
      nxt.opcode  = opc_sel;
      nxt.quanta  = opq_i[15:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         q <= '0;
      else if (capture_i) q <= nxt;
   end

   assign fields_o = q;

   p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> (fields_o.quanta == $past(opq_i[15:0])) &&
                    (fields_o.src == $past({lo_i, hi_i[31:16]})));

endmodule

// File: rtl/pfg_byte_seq.sv
module pfg_byte_seq
   import pfg_pkg::*;
#(
   parameter int unsigned FRAME_BYTES = 60,
   parameter logic [47:0] DEST_ADDR   = 48'h0180C2000001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          ready_i,
   input  pause_fields_t fields_i,
   output byte_t         data_o,
   output logic          valid_o,
   output logic          last_o,
   output logic          done_o
);

   localparam int unsigned CW       = $clog2(FRAME_BYTES);
   localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BYTES - 1);

   logic [CW-1:0] idx_q;
   logic          active_q;
   logic          beat;
   logic          at_end;
   int unsigned   k;

   assign beat   = active_q & ready_i;
   assign at_end = (idx_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         idx_q    <= '0;
      end else if (beat) begin
         if (at_end) begin
            active_q <= 1'b0;
            idx_q    <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // Field layout: DA(6) SA(6) type(2) opcode(2) quanta(2) then zero pad.
   always_comb begin
      k      = 32'(idx_q);
      data_o = 8'h00;
      if (k < 6)        data_o = addr_byte(DEST_ADDR, k);
      else if (k < 12)  data_o = addr_byte(fields_i.src, k - 6);
      else if (k == 12) data_o = fields_i.ethtype[15:8];
      else if (k == 13) data_o = fields_i.ethtype[7:0];
      else if (k == 14) data_o = fields_i.opcode[15:8];
      else if (k == 15) data_o = fields_i.opcode[7:0];
      else if (k == 16) data_o = fields_i.quanta[15:8];
      else if (k == 17) data_o = fields_i.quanta[7:0];
   end

   assign valid_o = active_q;
   assign last_o  = active_q & at_end;
   assign done_o  = beat & at_end;

   p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

   p_end_drops_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !valid_o);

endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
   import pfg_pkg::*;
#(
   parameter int unsigned FRAME_BYTES     = 60,
   parameter logic [47:0] DEST_ADDR       = 48'h0180C2000001,
   parameter bit          TYPE_FROM_REG   = 1'b1,
   parameter bit          OPCODE_FROM_REG = 1'b1,
   parameter logic [15:0] FIXED_TYPE      = 16'h8808,
   parameter logic [15:0] FIXED_OPCODE    = 16'h0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] stn_addr_lo_i,
   input  logic [31:0] stn_addr_hi_i,
   input  logic [31:0] op_quanta_i,
   input  logic        full_duplex_i,
   input  logic        pause_req_i,
   input  logic        tx_busy_i,
   input  logic        tx_ready_i,
   output logic [7:0]  tx_data_o,
   output logic        tx_valid_o,
   output logic        tx_last_o,
   output logic        pause_pending_o
);

   generate
      if (FRAME_BYTES < 18 || FRAME_BYTES > 65535) begin : g_bad_len
         $error("FRAME_BYTES must cover the 18 header bytes and fit 16 bits");
      end
      if (DEST_ADDR[40] != 1'b1) begin : g_bad_da
         $error("DEST_ADDR must be a group address");
      end
   endgenerate

   pause_fields_t fields;
   logic          start;
   logic          done;
   byte_t         data;

   pfg_req_ctrl u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (pause_req_i),
      .done_i    (done),
      .idle_i    (~tx_valid_o),
      .busy_i    (tx_busy_i),
      .fd_i      (full_duplex_i),
      .pending_o (pause_pending_o),
      .start_o   (start)
   );

   pfg_field_latch #(
      .TYPE_FROM_REG   (TYPE_FROM_REG),
      .OPCODE_FROM_REG (OPCODE_FROM_REG),
      .FIXED_TYPE      (FIXED_TYPE),
      .FIXED_OPCODE    (FIXED_OPCODE)
   ) u_fields (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (start),
      .lo_i      (stn_addr_lo_i),
      .hi_i      (stn_addr_hi_i),
      .opq_i     (op_quanta_i),
      .fields_o  (fields)
   );

   pfg_byte_seq #(
      .FRAME_BYTES (FRAME_BYTES),
      .DEST_ADDR   (DEST_ADDR)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .ready_i  (tx_ready_i),
      .fields_i (fields),
      .data_o   (data),
      .valid_o  (tx_valid_o),
      .last_o   (tx_last_o),
      .done_o   (done)
   );

   assign tx_data_o = data;

   // Independent count of accepted bytes, used only by the checks below.
   logic [15:0] seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                          seen_q <= '0;
      else if (tx_valid_o && tx_ready_i)   seen_q <= tx_last_o ? 16'd0 : seen_q + 16'd1;
   end

   p_frame_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && tx_ready_i && tx_last_o) |-> (seen_q == 16'(FRAME_BYTES - 1)));

   p_defer_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid_o) |-> $past(!tx_busy_i));

   p_duplex_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid_o) |-> $past(full_duplex_i && pause_pending_o));

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!tx_valid_o && !pause_pending_o));

endmodule

// File: tb/pause_frame_gen_bench.sv
module pause_frame_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] lo, hi, oq;
   logic        fd, busy, req, ready;
   logic [7:0]  data;
   logic        valid, last, pending;
   int          checks = 0;
   int          fails  = 0;

   always #5 clk = ~clk;

   pause_frame_gen u_pause_frame_gen (
      .clk (clk), .rst_n (rst_n),
      .stn_addr_lo_i (lo), .stn_addr_hi_i (hi), .op_quanta_i (oq),
      .full_duplex_i (fd), .pause_req_i (req), .tx_busy_i (busy),
      .tx_ready_i (ready), .tx_data_o (data), .tx_valid_o (valid),
      .tx_last_o (last), .pause_pending_o (pending)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int i, input logic [31:0] l,
                                           input logic [31:0] h, input logic [31:0] o);
      logic [47:0] da;
      logic [47:0] sa;
      da = 48'h0180C2000001;
      sa = {l, h[31:16]};
      if (i < 6)   return 8'((da >> (8 * (5 - i))) & 48'hFF);
      if (i < 12)  return 8'((sa >> (8 * (11 - i))) & 48'hFF);
      case (i)
         12: return h[15:8];
         13: return h[7:0];
         14: return o[31:24];
         15: return o[23:16];
         16: return o[15:8];
         17: return o[7:0];
         default: return 8'h00;
      endcase
   endfunction

   function automatic string req_of(input int i);
      if (i < 6)  return "R5";
      if (i < 12) return "R6";
      if (i < 14) return "R7";
      if (i < 18) return "R8";
      return "R9";
   endfunction

   task automatic pulse_req();
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
   endtask

   // Collect one frame; scramble moves the config words mid-frame (R11),
   // set_on_last raises a new request in the accept cycle of byte 59 (R12).
   task automatic recv_frame(input logic [31:0] l, input logic [31:0] h,
                             input logic [31:0] o, input bit scramble,
                             input bit set_on_last, input int pct);
      int    idx = 0;
      bit    stalled = 0;
      bit    done = 0;
      int    guard = 0;
      logic [7:0] pd = 8'h00;
      while (!done) begin
         @(negedge clk);
         guard++;
         if (guard > 3000) begin
            chk(1'b0, "R9", "frame never completed", idx, 60);
            return;
         end
         if (valid) begin
            if (stalled) chk(data == pd, "R10", "data under stall", data, pd);
            chk(data == exp_byte(idx, l, h, o), req_of(idx), $sformatf("byte %0d", idx),
                data, exp_byte(idx, l, h, o));
            chk(last == (idx == 59), "R9", $sformatf("last flag at %0d", idx),
                last, int'(idx == 59));
            ready = (($urandom % 100) < pct);
            if (ready) begin
               if (scramble && idx == 0) begin
                  lo = $urandom; hi = $urandom; oq = $urandom;
               end
               if (last) begin
                  done = 1;
                  if (set_on_last) req = 1'b1;
               end
               idx++;
               stalled = 0;
            end else begin
               stalled = 1;
               pd = data;
            end
         end else begin
            if (idx > 0) chk(1'b0, "R10", "valid dropped mid-frame", 0, 1);
            ready = $urandom % 2;
         end
      end
      @(negedge clk);
      req = 1'b0; ready = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; lo = '0; hi = '0; oq = '0;
      fd = 1'b1; busy = 1'b0; req = 1'b0; ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!valid, "R1", "valid after reset", valid, 0);
      chk(!last, "R1", "last after reset", last, 0);
      chk(!pending, "R1", "pending after reset", pending, 0);

      // R2: start latency, normal register values
      lo = 32'h11223344; hi = 32'h55668808; oq = 32'h00010020;
      pulse_req();
      chk(pending, "R2", "pending one edge after pulse", pending, 1);
      chk(!valid, "R2", "valid not yet", valid, 0);
      @(negedge clk);
      chk(valid, "R2", "valid two edges after pulse", valid, 1);
      recv_frame(lo, hi, oq, 1'b0, 1'b0, 100);
      chk(!pending, "R12", "pending cleared", pending, 0);

      // R3: deferral while the path is busy
      busy = 1'b1;
      pulse_req();
      repeat (6) @(negedge clk);
      chk(!valid, "R3", "no start while busy", valid, 0);
      chk(pending, "R3", "still pending while busy", pending, 1);
      busy = 1'b0;
      @(negedge clk);
      chk(valid, "R3", "start after busy falls", valid, 1);
      recv_frame(lo, hi, oq, 1'b0, 1'b0, 70);

      // R4: half duplex holds the request
      fd = 1'b0;
      lo = 32'hA0B0C0D0; hi = 32'hE0F08808; oq = 32'h0001FFFF;
      pulse_req();
      repeat (6) @(negedge clk);
      chk(!valid, "R4", "no start in half duplex", valid, 0);
      chk(pending, "R4", "request held in half duplex", pending, 1);
      fd = 1'b1;
      @(negedge clk);
      chk(valid, "R4", "start once full duplex", valid, 1);
      recv_frame(lo, hi, oq, 1'b0, 1'b0, 100);

      // R11: config words change after the first byte
      lo = 32'hDEADBEEF; hi = 32'hCAFE1234; oq = 32'h5A5A0F0F;
      pulse_req();
      recv_frame(lo, hi, oq, 1'b1, 1'b0, 50);
      chk(!pending, "R12", "pending cleared after scrambled frame", pending, 0);

      // R12: new request in the same cycle as the last byte
      lo = 32'h01020304; hi = 32'h05068808; oq = 32'h00010100;
      pulse_req();
      recv_frame(lo, hi, oq, 1'b0, 1'b1, 60);
      chk(pending, "R12", "same-cycle request kept", pending, 1);
      chk(!valid, "R12", "one idle cycle between frames", valid, 0);
      lo = 32'h77665544; oq = 32'h00010042;
      recv_frame(lo, hi, oq, 1'b0, 1'b0, 80);
      chk(!pending, "R12", "pending cleared after second frame", pending, 0);

      // Random frames with random backpressure and busy gating
      for (int f = 0; f < 24; f++) begin
         lo = $urandom; hi = $urandom; oq = $urandom;
         busy = $urandom % 2;
         pulse_req();
         if (busy) begin
            repeat (1 + $urandom % 4) @(negedge clk);
            chk(!valid, "R3", "random busy blocks start", valid, 0);
            busy = 1'b0;
         end
         recv_frame(lo, hi, oq, f[0], 1'b0, 30 + int'($urandom % 71));
         chk(!pending, "R12", "random frame clears pending", pending, 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule